// File: doc/BRIEF.md
# Fused Multiply-Subtract Special-Operand Resolver

This block sits at the front of a single-precision fused multiply-subtract unit that computes `addend - (mul_a * mul_b)`. It takes the three raw operand encodings and sorts each one into a class: zero, denormal, normal, infinity, quiet NaN or signalling NaN. From those classes it decides whether the result is already known or whether the arithmetic datapath has to run.

When the result is known, the block raises a bypass flag and supplies the finished 32-bit word. That word can be a propagated or quieted NaN, the default NaN, a signed infinity or the addend passed through. The block also flags an invalid operation when one occurs. Otherwise it raises a compute-enable flag for the datapath.

NaN inputs are resolved in a fixed priority order across the three operands. A quiet-NaN addend takes precedence over every infinity and invalid outcome that the product would otherwise produce. All outputs are registered, so a decision appears one clock after its operands are applied.

Top module: `fms_special_resolver`

## Requirements
- R1: An operand whose exponent field is all ones is an infinity when its fraction is zero. It is a quiet NaN when fraction bit 22 is 1, and a signalling NaN otherwise. An operand whose exponent field is zero is a zero when its fraction is zero and a denormal otherwise. Every other operand is normal. A denormal multiplicand counts as finite and nonzero.
- R2: A signalling-NaN addend wins over every other input. It gives bypass and invalid, and the result is the addend with fraction bit 22 set and all other bits kept.
- R3: If the addend is not a signalling NaN and `mul_a` is a signalling NaN, the result is `mul_a` quieted, with invalid raised. This holds whatever the class of `mul_b`, including a signalling NaN, and whatever a quiet-NaN addend holds.
- R4: If only `mul_b` is a signalling NaN, the result is `mul_b` quieted, with invalid raised. This holds even when `mul_a` is a quiet NaN.
- R5: With no signalling NaN present, a quiet-NaN `mul_a` is returned unchanged. Failing that, a quiet-NaN `mul_b` is returned unchanged. Invalid stays low, and a quiet-NaN addend does not override either case.
- R6: An infinity times a zero, in either order, returns a quiet-NaN addend unchanged. Otherwise it raises invalid and returns the default NaN 0x7FC00000.
- R7: For an infinite product that is not invalid, a quiet-NaN addend is returned unchanged. An infinite addend whose sign bit equals `sign(mul_a) XOR sign(mul_b)` raises invalid and returns 0x7FC00000. In every other case the result is infinity (exponent all ones, fraction zero) with sign bit `NOT(sign(mul_a) XOR sign(mul_b))`.
- R8: For a zero product, the addend is returned bit for bit, whatever its class apart from a NaN that outranks it.
- R9: For a finite nonzero product, a quiet-NaN or infinite addend is returned unchanged. Otherwise compute-enable is 1, bypass and invalid are 0, and the result word is 0.
- R10: Reset clears all four outputs to 0. After the first clock out of reset, exactly one of bypass and compute-enable is 1. Outputs reflect the operands present at the preceding rising clock edge.
- R11: Invalid is only ever 1 together with bypass, and every result produced with invalid is a quiet NaN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addend_i | input | 32 | Operand from which the product is subtracted |
| mul_a_i | input | 32 | First multiplicand |
| mul_b_i | input | 32 | Second multiplicand |
| bypass_o | output | 1 | Result is known; use result_o |
| result_o | output | 32 | Special-case result word |
| invalid_o | output | 1 | Invalid-operation flag |
| compute_o | output | 1 | Arithmetic datapath must produce the result |

## Verification
The bench builds the block with its default field widths: an 8-bit exponent and a 23-bit fraction. With these widths every encoding in the requirements is a literal single-precision word. That brings the quiet bit at position 22, the default NaN 0x7FC00000 and the infinity patterns directly within reach of hand-computed expectations. A vector table covers each rung of the NaN priority ladder, and each product class (invalid, infinite, zero, finite) against quiet-NaN, infinite and ordinary addends. Directed steps then cover reset mid-run and the one-cycle register latency.

// File: rtl/fms_pkg.sv
package fms_pkg;

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_DNORM,
        CL_NORM,
        CL_INF,
        CL_QNAN,
        CL_SNAN
    } opclass_e;

    localparam int DEF_EXP_W  = 8;
    localparam int DEF_FRAC_W = 23;
    localparam int NUM_OPS    = 3;

    localparam int IDX_ADDEND = 0;
    localparam int IDX_MUL_A  = 1;
    localparam int IDX_MUL_B  = 2;

endpackage

// File: rtl/fms_classify.sv
module fms_classify
    import fms_pkg::*;
#(
    parameter int EXP_W  = DEF_EXP_W,
    parameter int FRAC_W = DEF_FRAC_W
) (
    input  logic [EXP_W+FRAC_W:0] op_i,
    output opclass_e              cls_o,
    output logic                  sign_o,
    output logic [EXP_W+FRAC_W:0] quiet_o
);
    localparam int WORD_W = EXP_W + FRAC_W + 1;
    localparam logic [WORD_W-1:0] QUIET_BIT =
        {{(EXP_W+1){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [EXP_W-1:0]  exp_fld;
    logic [FRAC_W-1:0] frac_fld;

    assign exp_fld  = op_i[WORD_W-2 -: EXP_W];
    assign frac_fld = op_i[FRAC_W-1:0];
    assign sign_o   = op_i[WORD_W-1];
    assign quiet_o  = op_i | QUIET_BIT;

    // R1: class decode from exponent and fraction fields
    always_comb begin
        if (&exp_fld) begin
            if (frac_fld == '0)
                cls_o = CL_INF;
            else if (frac_fld[FRAC_W-1])
                cls_o = CL_QNAN;
            else
                cls_o = CL_SNAN;
        end else if (exp_fld == '0) begin
            cls_o = (frac_fld == '0) ? CL_ZERO : CL_DNORM;
        end else begin
            cls_o = CL_NORM;
        end
    end

endmodule

// File: rtl/fms_nan_pick.sv
module fms_nan_pick
    import fms_pkg::*;
#(
    parameter int WORD_W = DEF_EXP_W + DEF_FRAC_W + 1
) (
    input  opclass_e          cls_a_i,
    input  opclass_e          cls_b_i,
    input  logic [WORD_W-1:0] raw_a_i,
    input  logic [WORD_W-1:0] raw_b_i,
    input  logic [WORD_W-1:0] quiet_a_i,
    input  logic [WORD_W-1:0] quiet_b_i,
    output logic              hit_o,
    output logic              invalid_o,
    output logic [WORD_W-1:0] value_o
);
    // Fixed multiplicand ladder: sNaN a, sNaN b, qNaN a, qNaN b (R3, R4, R5)
    always_comb begin
        hit_o     = 1'b1;
        invalid_o = 1'b0;
        value_o   = '0;
        if (cls_a_i == CL_SNAN) begin
            invalid_o = 1'b1;
            value_o   = quiet_a_i;
        end else if (cls_b_i == CL_SNAN) begin
            invalid_o = 1'b1;
            value_o   = quiet_b_i;
        end else if (cls_a_i == CL_QNAN) begin
            value_o   = raw_a_i;
        end else if (cls_b_i == CL_QNAN) begin
            value_o   = raw_b_i;
        end else begin
            hit_o     = 1'b0;
        end
    end

endmodule

// File: rtl/fms_special_resolver.sv
module fms_special_resolver
    import fms_pkg::*;
#(
    parameter int EXP_W  = DEF_EXP_W,
    parameter int FRAC_W = DEF_FRAC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [EXP_W+FRAC_W:0]    addend_i,
    input  logic [EXP_W+FRAC_W:0]    mul_a_i,
    input  logic [EXP_W+FRAC_W:0]    mul_b_i,
    output logic                     bypass_o,
    output logic [EXP_W+FRAC_W:0]    result_o,
    output logic                     invalid_o,
    output logic                     compute_o
);
    localparam int WORD_W = EXP_W + FRAC_W + 1;
    localparam logic [WORD_W-1:0] DEFAULT_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] INF_MAG =
        {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};

    typedef struct packed {
        logic              bypass;
        logic              invalid;
        logic              compute;
        logic [WORD_W-1:0] result;
    } decision_t;

    logic [WORD_W-1:0] raw_ops   [NUM_OPS];
    logic [WORD_W-1:0] quiet_ops [NUM_OPS];
    opclass_e          cls_ops   [NUM_OPS];
    logic              sgn_ops   [NUM_OPS];

    assign raw_ops[IDX_ADDEND] = addend_i;
    assign raw_ops[IDX_MUL_A]  = mul_a_i;
    assign raw_ops[IDX_MUL_B]  = mul_b_i;

    for (genvar gi = 0; gi < NUM_OPS; gi++) begin : g_cls
        fms_classify #(
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W)
        ) u_cls (
            .op_i    (raw_ops[gi]),
            .cls_o   (cls_ops[gi]),
            .sign_o  (sgn_ops[gi]),
            .quiet_o (quiet_ops[gi])
        );
    end

    logic              nan_hit;
    logic              nan_inv;
    logic [WORD_W-1:0] nan_val;

    fms_nan_pick #(
        .WORD_W (WORD_W)
    ) u_nan (
        .cls_a_i   (cls_ops[IDX_MUL_A]),
        .cls_b_i   (cls_ops[IDX_MUL_B]),
        .raw_a_i   (raw_ops[IDX_MUL_A]),
        .raw_b_i   (raw_ops[IDX_MUL_B]),
        .quiet_a_i (quiet_ops[IDX_MUL_A]),
        .quiet_b_i (quiet_ops[IDX_MUL_B]),
        .hit_o     (nan_hit),
        .invalid_o (nan_inv),
        .value_o   (nan_val)
    );

    decision_t dec_d, dec_q;

    logic add_qnan, add_inf, prod_sign;
    logic inf_times_zero, prod_inf, prod_zero;

    always_comb begin
        add_qnan  = (cls_ops[IDX_ADDEND] == CL_QNAN);
        add_inf   = (cls_ops[IDX_ADDEND] == CL_INF);
        // product is subtracted, so its effective sign is inverted (R7)
        prod_sign = ~(sgn_ops[IDX_MUL_A] ^ sgn_ops[IDX_MUL_B]);
        inf_times_zero =
            (cls_ops[IDX_MUL_A] == CL_INF  && cls_ops[IDX_MUL_B] == CL_ZERO) ||
            (cls_ops[IDX_MUL_A] == CL_ZERO && cls_ops[IDX_MUL_B] == CL_INF);
        prod_inf  = (cls_ops[IDX_MUL_A] == CL_INF) || (cls_ops[IDX_MUL_B] == CL_INF);
        prod_zero = (cls_ops[IDX_MUL_A] == CL_ZERO) || (cls_ops[IDX_MUL_B] == CL_ZERO);

        dec_d        = '0;
        dec_d.bypass = 1'b1;

        if (cls_ops[IDX_ADDEND] == CL_SNAN) begin
            dec_d.invalid = 1'b1;
            dec_d.result  = quiet_ops[IDX_ADDEND];
        end else if (nan_hit) begin
            dec_d.invalid = nan_inv;
            dec_d.result  = nan_val;
        end else if (inf_times_zero) begin
            if (add_qnan) begin
                dec_d.result  = addend_i;
            end else begin
                dec_d.invalid = 1'b1;
                dec_d.result  = DEFAULT_NAN;
            end
        end else if (prod_inf) begin
            if (add_qnan) begin
                dec_d.result  = addend_i;
            end else if (add_inf && (sgn_ops[IDX_ADDEND] != prod_sign)) begin
                dec_d.invalid = 1'b1;
                dec_d.result  = DEFAULT_NAN;
            end else begin
                dec_d.result  = INF_MAG | {prod_sign, {(WORD_W-1){1'b0}}};
            end
        end else if (prod_zero) begin
            dec_d.result = addend_i;
        end else if (add_qnan || add_inf) begin
            dec_d.result = addend_i;
        end else begin
            dec_d.bypass  = 1'b0;
            dec_d.compute = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dec_q <= '0;
        else
            dec_q <= dec_d;
    end

    assign bypass_o  = dec_q.bypass;
    assign invalid_o = dec_q.invalid;
    assign compute_o = dec_q.compute;
    assign result_o  = dec_q.result;

endmodule

// File: rtl/fms_resolver_chk.sv
module fms_resolver_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [EXP_W+FRAC_W:0] addend_i,
    input logic                  bypass_o,
    input logic [EXP_W+FRAC_W:0] result_o,
    input logic                  invalid_o,
    input logic                  compute_o
);
    localparam int WORD_W = EXP_W + FRAC_W + 1;
    localparam logic [WORD_W-1:0] QUIET_BIT =
        {{(EXP_W+1){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    logic add_snan;
    assign add_snan = (&addend_i[WORD_W-2 -: EXP_W]) &&
                      !addend_i[FRAC_W-1] && (addend_i[FRAC_W-2:0] != '0);

    p_one_path_r10: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> $onehot({bypass_o, compute_o}));

    p_invalid_bypass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> bypass_o);

    p_invalid_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> ((&result_o[WORD_W-2 -: EXP_W]) && result_o[FRAC_W-1]));

    p_compute_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        compute_o |-> (!invalid_o && result_o == '0));

    p_snan_addend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        add_snan |=> (bypass_o && invalid_o && result_o == ($past(addend_i) | QUIET_BIT)));

endmodule

bind fms_special_resolver fms_resolver_chk #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addend_i  (addend_i),
    .bypass_o  (bypass_o),
    .result_o  (result_o),
    .invalid_o (invalid_o),
    .compute_o (compute_o)
);

// File: tb/sim_fms_special_resolver.sv
module sim_fms_special_resolver;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] addend_i = '0;
    logic [31:0] mul_a_i = '0;
    logic [31:0] mul_b_i = '0;
    logic        bypass_o, invalid_o, compute_o;
    logic [31:0] result_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fms_special_resolver u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .addend_i  (addend_i),
        .mul_a_i   (mul_a_i),
        .mul_b_i   (mul_b_i),
        .bypass_o  (bypass_o),
        .result_o  (result_o),
        .invalid_o (invalid_o),
        .compute_o (compute_o)
    );

    // {req[3:0], addend, mul_a, mul_b, expected result, {bypass, invalid, compute}}
    localparam int NV = 22;
    localparam logic [134:0] VEC [NV] = '{
        {4'd2,  32'h7F800005, 32'hFFA00003, 32'h3F800000, 32'h7FC00005, 3'b110}, // R2
        {4'd3,  32'h3F800000, 32'hFFA00003, 32'h7F800005, 32'hFFE00003, 3'b110}, // R3
        {4'd3,  32'h7FC00001, 32'hFFA00003, 32'h7F800000, 32'hFFE00003, 3'b110}, // R3
        {4'd4,  32'h3F800000, 32'h7FD00000, 32'h7F800005, 32'h7FC00005, 3'b110}, // R4
        {4'd5,  32'h3F800000, 32'h7FD00000, 32'h7FC00001, 32'h7FD00000, 3'b100}, // R5
        {4'd5,  32'h7FC00001, 32'h3F800000, 32'h7FD00000, 32'h7FD00000, 3'b100}, // R5
        {4'd6,  32'h3F800000, 32'h7F800000, 32'h00000000, 32'h7FC00000, 3'b110}, // R6
        {4'd6,  32'h7FC00001, 32'h80000000, 32'hFF800000, 32'h7FC00001, 3'b100}, // R6
        {4'd7,  32'h3F800000, 32'h7F800000, 32'h40000000, 32'hFF800000, 3'b100}, // R7
        {4'd7,  32'h3F800000, 32'hFF800000, 32'h00000001, 32'h7F800000, 3'b100}, // R7
        {4'd7,  32'h7F800000, 32'h7F800000, 32'h3F800000, 32'h7FC00000, 3'b110}, // R7
        {4'd7,  32'hFF800000, 32'h7F800000, 32'h3F800000, 32'hFF800000, 3'b100}, // R7
        {4'd7,  32'h7FC00001, 32'h7F800000, 32'h7F800000, 32'h7FC00001, 3'b100}, // R7
        {4'd8,  32'hFF800000, 32'h00000000, 32'h40000000, 32'hFF800000, 3'b100}, // R8
        {4'd8,  32'hBF800000, 32'h80000000, 32'h40000000, 32'hBF800000, 3'b100}, // R8
        {4'd8,  32'h7FC00001, 32'h00000000, 32'h00000000, 32'h7FC00001, 3'b100}, // R8
        {4'd9,  32'h3F800000, 32'h40000000, 32'h3F800000, 32'h00000000, 3'b001}, // R9
        {4'd9,  32'h00000001, 32'h00000001, 32'h00000001, 32'h00000000, 3'b001}, // R9
        {4'd9,  32'h7FC00001, 32'h3F800000, 32'h40000000, 32'h7FC00001, 3'b100}, // R9
        {4'd9,  32'h7F800000, 32'hBF800000, 32'h40000000, 32'h7F800000, 3'b100}, // R9
        {4'd1,  32'h00000000, 32'h00400000, 32'hFF800000, 32'h7F800000, 3'b100}, // R1
        {4'd1,  32'h3F800000, 32'h7F800001, 32'h3F800000, 32'h7FC00001, 3'b110}  // R1
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10 reset flags", {29'd0, bypass_o, invalid_o, compute_o}, 32'd0);
        check("R10 reset result", result_o, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [134:0] v;
            string tag;
            v = VEC[i];
            @(negedge clk);
            addend_i = v[130:99];
            mul_a_i  = v[98:67];
            mul_b_i  = v[66:35];
            @(negedge clk);
            tag = $sformatf("R%0d vec%0d", v[134:131], i);
            check({tag, " result"}, result_o, v[34:3]);
            check({tag, " flags"}, {29'd0, bypass_o, invalid_o, compute_o}, {29'd0, v[2:0]});
            // R11: invalid implies bypass
            check("R11 invalid without bypass", {31'd0, invalid_o & ~bypass_o}, 32'd0);
            // R10: exactly one path
            check("R10 one path", {31'd0, bypass_o ^ compute_o}, 32'd1);
        end

        // R10: one-cycle latency, old value held until the next edge
        @(negedge clk);
        addend_i = 32'h3F800000; mul_a_i = 32'h40000000; mul_b_i = 32'h40000000;
        @(negedge clk);
        check("R10 compute before change", {31'd0, compute_o}, 32'd1);
        addend_i = 32'h7F800005;
        #1;
        check("R10 held before edge", {31'd0, compute_o}, 32'd1);
        @(negedge clk);
        check("R2 after edge", result_o, 32'h7FC00005);
        check("R2 invalid after edge", {31'd0, invalid_o}, 32'd1);

        // R10: reset mid-run clears outputs
        rst_n = 1'b0;
        #1;
        check("R10 mid reset flags", {29'd0, bypass_o, invalid_o, compute_o}, 32'd0);
        check("R10 mid reset result", result_o, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 after reset release", result_o, 32'h7FC00005);

        finish_run();
    end

endmodule